// File: doc/BRIEF.md
# Edge-Driven Event Counter with Match Clear

This block counts falling edges on an external input pin. The pin is asynchronous to the system clock, so it passes through a two-stage synchroniser before edge detection. A 16-bit up-counter advances once for each detected falling edge while the run bit is high. When the next count would equal the programmed compare value, the counter returns to zero and the block raises a single-cycle interrupt pulse. The edge after that produces a count of 1.

Software loads the 16-bit compare value over a byte-wide write port. The low byte goes into a holding register. Writing the high byte then commits both bytes to the compare register at once. The committed value is used directly, with no shadow copy, so a new value applies from the very next edge. When the run bit is low, the counter stays at zero and no interrupt is produced.

Top module: `edge_event_counter`

## Requirements
- R1: After an asynchronous reset, `count_o` is 0 and `irq_o` is 0.
- R2: With `start_i` high, each falling edge of `pin_i` raises `count_o` by one. The new count shows on the third rising clock edge after the pin falls: two edges for synchronisation and one for the counter.
- R3: Input high and low phases as short as two clock cycles are each recognised, so one edge is counted every four cycles.
- R4: When an edge would bring the count to the compare value, `count_o` becomes 0 instead, and `irq_o` is high for exactly one cycle on that same edge.
- R5: After a match clear, the next falling edge produces a count of 1.
- R6: A write with `wr_hi_i`=0 loads `wr_data_i` into a low-byte holding register. A write with `wr_hi_i`=1 sets the compare value to {`wr_data_i`, holding register}, with the high byte in bits 15:8.
- R7: A low-byte write alone leaves the compare value used for matching unchanged.
- R8: A compare value committed while counting is used from the next edge onward. It is not deferred to a match.
- R9: While `start_i` is 0, `count_o` is held at 0, edges are ignored and no interrupt occurs. Dropping `start_i` mid-count clears `count_o` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External event input, asynchronous |
| wr_en_i | input | 1 | Compare byte write strobe |
| wr_hi_i | input | 1 | Byte select: 0 = low byte, 1 = high byte (commit) |
| wr_data_i | input | 8 | Compare byte data |
| start_i | input | 1 | Run bit; 0 holds the counter at zero |
| irq_o | output | 1 | One-cycle pulse on match clear |
| count_o | output | 16 | Current count |

## Verification
The hardest case to reach is a compare value whose high byte is non-zero. Matching it needs hundreds of edges, and an early wrong match would show up only as a stray interrupt. The stimulus programs 0x0103 and sends 258 edges with minimum-width phases. It checks that no interrupt has occurred and that the count reads 258, then sends one more edge and expects a clear. A second targeted case rewrites the compare value in the middle of a count. A third issues a lone low-byte write between matches, so that an unwanted commit would move the next interrupt.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ecnt_edge_detect.sv
module ecnt_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  // sh[SYNC_STAGES-1] is the synchronised level, sh[SYNC_STAGES] its previous sample
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh[0] <= 1'b1;
    else         sh[0] <= pin_i;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh[i] <= 1'b1;
      else         sh[i] <= sh[i-1];
    end
  end

  assign fall_o = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/ecnt_cmp_reg.sv
module ecnt_cmp_reg
  import ecnt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  wr_hi_i,
  input  byte_t wr_data_i,
  output cnt_t  cmp_o
);
  byte_t lo_hold;
  cnt_t  cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_hold <= '0;
      cmp_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_hi_i) cmp_q   <= {wr_data_i, lo_hold};
      else         lo_hold <= wr_data_i;
    end
  end

  assign cmp_o = cmp_q;

  AST_CMP_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i) |=> (cmp_o[CNT_W-1:BYTE_W] == $past(wr_data_i))); // R6
  AST_LO_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i) |=> $stable(cmp_o)); // R7
endmodule

// File: rtl/ecnt_core.sv
module ecnt_core
  import ecnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fall_i,
  input  cnt_t cmp_i,
  output cnt_t count_o,
  output logic irq_o
);
  cnt_t cnt_q;
  cnt_t cnt_inc;
  logic irq_q;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (!start_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (fall_i) begin
        if (cnt_inc == cmp_i) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R4
  AST_IRQ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o == '0)); // R4
  AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (count_o == '0 && !irq_o)); // R9
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !fall_i) |=> $stable(count_o)); // R2
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import ecnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              start_i,
  output logic              irq_o,
  output logic [CNT_W-1:0]  count_o
);
  logic fall;
  cnt_t cmp;

  ecnt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .fall_o(fall)
  );

  ecnt_cmp_reg u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_hi_i  (wr_hi_i),
    .wr_data_i(wr_data_i),
    .cmp_o    (cmp)
  );

  ecnt_core u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .fall_i (fall),
    .cmp_i  (cmp),
    .count_o(count_o),
    .irq_o  (irq_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (count_o == '0 || rst_ni)); // R1
endmodule

// File: tb/tb_edge_event_counter.sv
`timescale 1ns/1ps
module tb_edge_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        start = 1'b0;
  logic        irq;
  logic [15:0] count;

  always #2.5 clk = ~clk;

  edge_event_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .wr_hi_i(wr_hi), .wr_data_i(wr_data), .start_i(start),
    .irq_o(irq), .count_o(count)
  );

  typedef struct {
    logic [15:0] cnt;
    int          irqs;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  logic [15:0] m_cnt = '0;
  int m_irqs = 0;
  logic [15:0] m_cmp = '0;
  logic [7:0]  m_lo = '0;
  bit done = 0;

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  // monitor: pop and compare expected items
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (count !== e.cnt || irq_cnt != e.irqs) begin
          errors++;
          $display("FAIL %s: count=%0d irqs=%0d expected count=%0d irqs=%0d",
                   e.req, count, irq_cnt, e.cnt, e.irqs);
        end
      end
    end
  end

  task automatic push(string req);
    exp_t e;
    e.cnt = m_cnt; e.irqs = m_irqs; e.req = req;
    exp_q.push_back(e);
  endtask

  // driver: one falling edge with phases of w cycles, model updated
  task automatic pulse(int w);
    @(negedge clk) pin = 1'b0;
    repeat (w) @(negedge clk);
    pin = 1'b1;
    repeat (w) @(negedge clk);
    if (start) begin
      if (m_cnt + 16'd1 == m_cmp) begin
        m_cnt = '0;
        m_irqs++;
      end else begin
        m_cnt = m_cnt + 16'd1;
      end
    end
  endtask

  task automatic wr_byte(bit hi, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi) m_cmp = {d, m_lo};
    else    m_lo = d;
  endtask

  task automatic wr_cmp(logic [15:0] v);
    wr_byte(1'b0, v[7:0]);
    wr_byte(1'b1, v[15:8]);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push("R1");                      // reset state
    settle();
    rst_n = 1'b1;
    settle();
    push("R1");

    // R9: stopped, edges ignored
    for (int i = 0; i < 3; i++) pulse(3);
    push("R9");

    wr_cmp(16'd5);
    @(negedge clk) start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pulse(3);
      push("R2");
    end
    pulse(2); push("R4");            // match clear with 2-cycle phases
    pulse(3); push("R5");
    pulse(2); push("R3");

    // R8: compare changed mid-count, used at once
    wr_cmp(16'd4);
    pulse(3); push("R8");
    pulse(3); push("R8");

    // R7: lone low-byte write leaves match value alone
    wr_byte(1'b0, 8'h02);
    for (int i = 0; i < 4; i++) begin
      pulse(3);
      push("R7");
    end

    // R6: high byte commits held low byte
    wr_byte(1'b1, 8'h00);
    pulse(3); push("R6");
    pulse(3); push("R6");

    // R6: non-zero high byte
    wr_cmp(16'h0103);
    for (int i = 0; i < 258; i++) pulse(2);
    push("R6");
    pulse(2); push("R6");
    pulse(2); push("R5");

    // R9: stop mid-count clears
    pulse(3);
    @(negedge clk) start = 1'b0;
    m_cnt = '0;
    settle();
    push("R9");
    pulse(3); pulse(2); push("R9");

    settle();
    settle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule